// File: doc/BRIEF.md
# Sigma-Delta Conversion Cadence and Ready Controller

This block decides when a sigma-delta converter's filtered result is committed to the data register, and drives the handshake flags that go with each commit. The modulator and decimation filter are modelled as a stream of already-filtered samples. The stream is a data word plus over-range and under-range markers, and it is always present at the block's input. The register file supplies the operating mode, the output-rate code, the clock-divide code and the selected channel. It also gives a one-cycle strobe whenever the mode register is written, and a one-cycle strobe when a serial read of the data register completes.

Output periods are counted in ticks of the block clock, which is taken as the base clock of `BASE_HZ` hertz. Every restart of the filter pipeline costs two output periods before the first result. After that, continuous mode commits one result per period. Single-shot mode first waits an oscillator wake-up time, then converts once and drops to power-down. Ready is active low. It is withdrawn by a completed read, by power-down, by any restart, and for a fixed blanking window before each continuous update. That window tells the reader not to start a read that would collide with the next update. Results that leave the converter's range are clamped and marked with an error flag.

Top module: `conv_cadence`

## Requirements
- R1: After reset, `rdy_n`=1, `err_flag`=0, `dreg_data`=0, `pwr_down`=0 and `dreg_load`=0. With continuous mode configured at reset, the first `dreg_load` comes 2·P clock edges after the last reset edge.
- R2: The output period is P = floor(BASE_HZ·10 / f) ticks at divide 1. The rate code maps to f in tenths of a hertz as follows: 000→1200, 001→1000, 010→333, 011→200, 100→166, 101→167, 110→133, 111→95.
- R3: Clock-divide codes 00, 01, 10 and 11 multiply P by 1, 2, 4 and 8.
- R4: A restart is a `mode_wr` strobe, or a change of `cfg_chan` from its value at the previous edge. After a restart into continuous mode, the first `dreg_load` comes 2·P edges after the restart edge, and `rdy_n` is 1 right after the restart edge.
- R5: In continuous mode (mode 00), each later `dreg_load` comes exactly P edges after the previous one.
- R6: Single mode (10) waits W = max(1, floor(BASE_HZ·WAKE_US/10^6)) ticks, then 2·P ticks, then gives one `dreg_load`, drives `rdy_n` low and `pwr_down` high, and gives no further loads.
- R7: Power-down (11) and the reserved code (01) drive `pwr_down` to 1 and `rdy_n` to 1 right after the write, and produce no `dreg_load` while they remain selected.
- R8: `rdy_n` goes low right after the edge that loads a result. `rdy_n` goes high right after the edge that samples `read_done`.
- R9: In continuous mode, `rdy_n` goes high BLANK_TICKS edges before each load, whether or not the previous result was read.
- R10: A load with `filt_over`=1 stores all ones; with only `filt_under`=1 it stores all zeros; in both cases `err_flag` is 1. Otherwise the load stores `filt_data` and `err_flag` becomes 0.
- R11: A restart into mode 00 or 10 clears `err_flag`. A restart into power-down leaves `err_flag` unchanged.
- R12: A `read_done` inside the blanking window does not move the next load. A `read_done` on the same edge as a load leaves `rdy_n` low.
- R13: An unread result is overwritten by the next load. `dreg_load` is a single-cycle strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock, BASE_HZ ticks per second |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_mode | input | 2 | Operating mode: 00 continuous, 01 reserved, 10 single, 11 power-down |
| cfg_rate | input | 3 | Output-rate code |
| cfg_cdiv | input | 2 | Clock-divide code |
| cfg_chan | input | 2 | Selected input channel; any change restarts |
| mode_wr | input | 1 | One-cycle strobe for a mode register write |
| read_done | input | 1 | One-cycle strobe when a data-register read completes |
| filt_data | input | DATA_W | Current filtered sample |
| filt_over | input | 1 | Sample is above full scale |
| filt_under | input | 1 | Sample is below negative full scale |
| rdy_n | output | 1 | Ready flag, low when an unread result is valid |
| err_flag | output | 1 | Last loaded result was clamped |
| dreg_load | output | 1 | One-cycle strobe when the data register is loaded |
| dreg_data | output | DATA_W | Data register contents |
| pwr_down | output | 1 | Converter is in power-down |

## Verification
The bench builds the block with BASE_HZ=12000 and keeps DATA_W=24, BLANK_TICKS=16 and WAKE_US=1000. At that base rate the periods run from 100 ticks (code 000) to 1263 ticks (code 111), and the wake-up time is 12 ticks. This keeps all eight rate codes and all four divide factors short enough to measure edge by edge. The blanking window and the single-shot wake-up stay clearly separate from the period. The window 16 ticks before each load can be probed at its exact boundary, and reads can be placed inside it and on the load edge itself.

// File: rtl/conv_cadence_pkg.sv
// Shared types and rate arithmetic for the conversion cadence controller.
// Assumes the base clock frequency is given in hertz and that output rates
// are expressed in tenths of a hertz.
package conv_cadence_pkg;

    typedef enum logic [1:0] {
        MD_CONT   = 2'b00,
        MD_RSVD   = 2'b01,
        MD_SINGLE = 2'b10,
        MD_OFF    = 2'b11
    } mode_e;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_WAKE,
        ST_SETTLE,
        ST_CONV,
        ST_RUN
    } seq_e;

    // Output word rate in tenths of a hertz for each rate code.
    function automatic int unsigned rate_dhz(input logic [2:0] code);
        case (code)
            3'd0:    return 1200;
            3'd1:    return 1000;
            3'd2:    return 333;
            3'd3:    return 200;
            3'd4:    return 166;
            3'd5:    return 167;
            3'd6:    return 133;
            default: return 95;
        endcase
    endfunction

    // Base-clock ticks per output period at divide-by-one.
    function automatic int unsigned base_period(input int unsigned base_hz,
                                                input logic [2:0] code);
        return (base_hz * 10) / rate_dhz(code);
    endfunction

endpackage

// File: rtl/conv_cadence_period.sv
// Output-period lookup. Builds a constant table of the eight base periods
// from BASE_HZ and scales the selected entry by the clock-divide factor.
// Assumes CNT_W is wide enough for 16 times the longest base period.
module conv_cadence_period
    import conv_cadence_pkg::*;
#(
    parameter int unsigned BASE_HZ = 65536,
    parameter int unsigned CNT_W   = 18
) (
    input  logic [2:0]       cfg_rate,
    input  logic [1:0]       cfg_cdiv,
    output logic [CNT_W-1:0] period
);
    localparam int NUM_RATES = 8;

    logic [CNT_W-1:0] base_tbl [NUM_RATES];

    // One constant table entry per rate code.
    for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
        assign base_tbl[g] = CNT_W'(base_period(BASE_HZ, 3'(g)));
    end

    // Scale the selected base period by 1, 2, 4 or 8.
    always_comb begin
        period = base_tbl[cfg_rate] << cfg_cdiv;
    end

endmodule

// File: rtl/conv_cadence_seq.sv
// Conversion sequencer. Tracks restarts (mode writes and channel changes),
// counts wake-up, settling and period ticks, and issues the load and
// blanking events. Assumes period > BLANK_TICKS + 1 for every setting.
module conv_cadence_seq
    import conv_cadence_pkg::*;
#(
    parameter int unsigned CNT_W       = 18,
    parameter int unsigned WAKE_TICKS  = 65,
    parameter int unsigned BLANK_TICKS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_mode,
    input  logic [1:0]       cfg_chan,
    input  logic             mode_wr,
    input  logic [CNT_W-1:0] period,
    output logic             restart,
    output logic             start_evt,
    output logic             load_evt,
    output logic             blank_evt,
    output logic             pwr_down
);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
    localparam logic [CNT_W-1:0] BLANK_AT = CNT_W'(BLANK_TICKS + 1);
    localparam logic [CNT_W-1:0] WAKE_CNT = CNT_W'(WAKE_TICKS);

    seq_e             state;
    logic [CNT_W-1:0] cnt;
    logic [1:0]       chan_q;
    seq_e             tgt_state;
    logic [CNT_W-1:0] tgt_cnt;
    logic             active;

    // Restart detection and event decode from the current counter.
    always_comb begin
        restart   = mode_wr || (cfg_chan != chan_q);
        start_evt = restart && (cfg_mode == MD_CONT || cfg_mode == MD_SINGLE);
        active    = (state == ST_SETTLE) || (state == ST_RUN) || (state == ST_CONV);
        load_evt  = !restart && active && (cnt == ONE);
        blank_evt = !restart && (state == ST_RUN) && (cnt == BLANK_AT);
        pwr_down  = (state == ST_OFF);
    end

    // Entry state and count for a restart in the configured mode.
    always_comb begin
        case (mode_e'(cfg_mode))
            MD_CONT: begin
                tgt_state = ST_SETTLE;
                tgt_cnt   = period << 1;
            end
            MD_SINGLE: begin
                tgt_state = ST_WAKE;
                tgt_cnt   = WAKE_CNT;
            end
            default: begin
                tgt_state = ST_OFF;
                tgt_cnt   = '0;
            end
        endcase
    end

    // Remember the channel to spot changes.
    always_ff @(posedge clk) begin
        if (!rst_n) chan_q <= cfg_chan;
        else        chan_q <= cfg_chan;
    end

    // Sequencer state and tick counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= tgt_state;
            cnt   <= tgt_cnt;
        end else if (restart) begin
            state <= tgt_state;
            cnt   <= tgt_cnt;
        end else begin
            case (state)
                ST_WAKE: begin
                    if (cnt == ONE) begin
                        state <= ST_CONV;
                        cnt   <= period << 1;
                    end else begin
                        cnt <= cnt - ONE;
                    end
                end
                ST_SETTLE, ST_RUN: begin
                    if (cnt == ONE) begin
                        state <= ST_RUN;
                        cnt   <= period;
                    end else begin
                        cnt <= cnt - ONE;
                    end
                end
                ST_CONV: begin
                    if (cnt == ONE) begin
                        state <= ST_OFF;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt - ONE;
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end

    // R4
    settle_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && cfg_mode == MD_CONT) |=> (cnt == ($past(period) << 1)));

    // R5
    live_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_OFF) |-> (cnt != '0));

    // R6
    single_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_evt && state == ST_CONV) |=> pwr_down);

    // R9
    blank_margin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (period > BLANK_AT));

endmodule

// File: rtl/conv_cadence_flags.sv
// Data register, ready flag and clamp error flag. Applies, in priority
// order: restart, result load, then read completion or blanking.
// Assumes the load, restart and blank events are one-cycle pulses.
module conv_cadence_flags #(
    parameter int unsigned DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              start_evt,
    input  logic              load_evt,
    input  logic              blank_evt,
    input  logic              read_done,
    input  logic [DATA_W-1:0] filt_data,
    input  logic              filt_over,
    input  logic              filt_under,
    output logic              rdy_n,
    output logic              err_flag,
    output logic              dreg_load,
    output logic [DATA_W-1:0] dreg_data
);
    logic [DATA_W-1:0] clamp_data;
    logic              clamp_err;

    // Saturate out-of-range samples; over-range wins over under-range.
    always_comb begin
        if (filt_over) begin
            clamp_data = '1;
            clamp_err  = 1'b1;
        end else if (filt_under) begin
            clamp_data = '0;
            clamp_err  = 1'b1;
        end else begin
            clamp_data = filt_data;
            clamp_err  = 1'b0;
        end
    end

    // Ready, error and data register updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_n     <= 1'b1;
            err_flag  <= 1'b0;
            dreg_load <= 1'b0;
            dreg_data <= '0;
        end else begin
            dreg_load <= load_evt;
            if (restart) begin
                rdy_n <= 1'b1;
                if (start_evt) err_flag <= 1'b0;
            end else if (load_evt) begin
                rdy_n     <= 1'b0;
                err_flag  <= clamp_err;
                dreg_data <= clamp_data;
            end else if (read_done || blank_evt) begin
                rdy_n <= 1'b1;
            end
        end
    end

    // R8
    ready_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_n) |-> $past(load_evt));

    // R10
    clamp_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dreg_load && err_flag) |-> (dreg_data == '0 || dreg_data == '1));

    // R11
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(err_flag) |-> $past(load_evt || start_evt));

endmodule

// File: rtl/conv_cadence.sv
// Conversion cadence and ready controller for a sigma-delta converter.
// Schedules data-register loads from mode, rate and divide settings and
// drives ready, clamp error and power-down. Assumes the clock is the base
// clock of BASE_HZ hertz and the register file holds the configuration.
module conv_cadence
    import conv_cadence_pkg::*;
#(
    parameter int unsigned BASE_HZ     = 65536,
    parameter int unsigned DATA_W      = 24,
    parameter int unsigned BLANK_TICKS = 16,
    parameter int unsigned WAKE_US     = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic [2:0]        cfg_rate,
    input  logic [1:0]        cfg_cdiv,
    input  logic [1:0]        cfg_chan,
    input  logic              mode_wr,
    input  logic              read_done,
    input  logic [DATA_W-1:0] filt_data,
    input  logic              filt_over,
    input  logic              filt_under,
    output logic              rdy_n,
    output logic              err_flag,
    output logic              dreg_load,
    output logic [DATA_W-1:0] dreg_data,
    output logic              pwr_down
);
    localparam int unsigned WAKE_RAW   = (BASE_HZ * WAKE_US) / 1000000;
    localparam int unsigned WAKE_TICKS = (WAKE_RAW < 1) ? 1 : WAKE_RAW;
    localparam int unsigned MAX_BASE   = base_period(BASE_HZ, 3'd7);
    localparam int unsigned CNT_W      = $clog2(MAX_BASE * 16 + WAKE_TICKS + BLANK_TICKS + 2);

    logic [CNT_W-1:0] period;
    logic             restart;
    logic             start_evt;
    logic             load_evt;
    logic             blank_evt;

    conv_cadence_period #(
        .BASE_HZ (BASE_HZ),
        .CNT_W   (CNT_W)
    ) u_period (
        .cfg_rate (cfg_rate),
        .cfg_cdiv (cfg_cdiv),
        .period   (period)
    );

    conv_cadence_seq #(
        .CNT_W       (CNT_W),
        .WAKE_TICKS  (WAKE_TICKS),
        .BLANK_TICKS (BLANK_TICKS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_mode  (cfg_mode),
        .cfg_chan  (cfg_chan),
        .mode_wr   (mode_wr),
        .period    (period),
        .restart   (restart),
        .start_evt (start_evt),
        .load_evt  (load_evt),
        .blank_evt (blank_evt),
        .pwr_down  (pwr_down)
    );

    conv_cadence_flags #(
        .DATA_W (DATA_W)
    ) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .start_evt  (start_evt),
        .load_evt   (load_evt),
        .blank_evt  (blank_evt),
        .read_done  (read_done),
        .filt_data  (filt_data),
        .filt_over  (filt_over),
        .filt_under (filt_under),
        .rdy_n      (rdy_n),
        .err_flag   (err_flag),
        .dreg_load  (dreg_load),
        .dreg_data  (dreg_data)
    );

    // R13
    load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dreg_load |=> !dreg_load);

    // R7
    quiet_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pwr_down) && pwr_down) |-> !dreg_load);

endmodule

// File: tb/sim_conv_cadence.sv
// Directed bench for conv_cadence: one task per scenario, each checking
// its own results at falling clock edges.
module sim_conv_cadence;
    localparam int CLK_PERIOD = 10;
    localparam int BASE       = 12000;
    localparam int BLANK      = 16;
    localparam int WAKE       = 12;
    localparam int LIMIT      = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mode = 2'b00;
    logic [2:0]  cfg_rate = 3'b100;
    logic [1:0]  cfg_cdiv = 2'b00;
    logic [1:0]  cfg_chan = 2'b00;
    logic        mode_wr = 1'b0;
    logic        read_done = 1'b0;
    logic [23:0] filt_data = 24'h123456;
    logic        filt_over = 1'b0;
    logic        filt_under = 1'b0;
    logic        rdy_n;
    logic        err_flag;
    logic        dreg_load;
    logic [23:0] dreg_data;
    logic        pwr_down;

    int total = 0;
    int bad = 0;

    conv_cadence #(.BASE_HZ(BASE)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_rate(cfg_rate),
        .cfg_cdiv(cfg_cdiv), .cfg_chan(cfg_chan), .mode_wr(mode_wr),
        .read_done(read_done), .filt_data(filt_data), .filt_over(filt_over),
        .filt_under(filt_under), .rdy_n(rdy_n), .err_flag(err_flag),
        .dreg_load(dreg_load), .dreg_data(dreg_data), .pwr_down(pwr_down)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Expected period from the rate table in tenths of a hertz.
    function automatic int per(input int code, input int div);
        int dhz [8] = '{1200, 1000, 333, 200, 166, 167, 133, 95};
        return ((BASE * 10) / dhz[code]) * (1 << div);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    // Count falling edges until a load is seen.
    task automatic wait_load(input int max, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!dreg_load && n < max);
    endtask

    // Count loads over a span of cycles.
    task automatic count_loads(input int span, output int c);
        c = 0;
        for (int i = 0; i < span; i++) begin
            @(negedge clk);
            if (dreg_load) c++;
        end
    endtask

    task automatic write_mode(input logic [1:0] m);
        @(negedge clk);
        cfg_mode = m;
        mode_wr  = 1'b1;
        @(negedge clk);
        mode_wr  = 1'b0;
    endtask

    task automatic t_reset();
        int n;
        step(3);
        rst_n = 1'b1;
        check("R1 rdy_n", int'(rdy_n), 1);
        check("R1 err", int'(err_flag), 0);
        check("R1 data", int'(dreg_data), 0);
        check("R1 pwr_down", int'(pwr_down), 0);
        check("R1 load", int'(dreg_load), 0);
        wait_load(5000, n);
        check("R1 first load", n, 2 * per(4, 0));
        check("R8 ready low", int'(rdy_n), 0);
        check("R10 data", int'(dreg_data), 32'h123456);
    endtask

    task automatic t_rates();
        int n;
        for (int c = 0; c < 8; c++) begin
            cfg_rate = 3'(c);
            write_mode(2'b00);
            wait_load(5000, n);
            check($sformatf("R2 settle code %0d", c), n, 2 * per(c, 0));
            wait_load(5000, n);
            check($sformatf("R5 period code %0d", c), n, per(c, 0));
        end
        cfg_rate = 3'b000;
    endtask

    task automatic t_cdiv();
        int n;
        for (int d = 1; d < 4; d++) begin
            cfg_cdiv = 2'(d);
            write_mode(2'b00);
            wait_load(5000, n);
            check($sformatf("R3 settle div %0d", d), n, 2 * per(0, d));
            wait_load(5000, n);
            check($sformatf("R3 period div %0d", d), n, per(0, d));
        end
        cfg_cdiv = 2'b00;
    endtask

    task automatic t_blank_overwrite();
        int n;
        int p = per(0, 0);
        write_mode(2'b00);
        wait_load(5000, n);
        filt_data = 24'hABCDEF;
        step(p - BLANK - 1);
        check("R9 before window", int'(rdy_n), 0);
        step(1);
        check("R9 window open", int'(rdy_n), 1);
        step(BLANK - 1);
        check("R9 no early load", int'(dreg_load), 0);
        step(1);
        check("R13 load", int'(dreg_load), 1);
        check("R13 ready again", int'(rdy_n), 0);
        check("R13 overwritten", int'(dreg_data), 32'hABCDEF);
        step(1);
        check("R13 one cycle", int'(dreg_load), 0);
    endtask

    task automatic t_read();
        int n;
        int p = per(0, 0);
        write_mode(2'b00);
        wait_load(5000, n);
        read_done = 1'b1;
        @(negedge clk);
        read_done = 1'b0;
        check("R8 read clears", int'(rdy_n), 1);
        wait_load(5000, n);
        check("R8 cadence kept", n, p - 1);
        // read inside blanking window, then on the load edge
        step(p - BLANK + 2);
        read_done = 1'b1;
        @(negedge clk);
        read_done = 1'b0;
        step(BLANK - 4);
        read_done = 1'b1;
        @(negedge clk);
        read_done = 1'b0;
        check("R12 load on time", int'(dreg_load), 1);
        check("R12 load wins", int'(rdy_n), 0);
    endtask

    task automatic t_clamp();
        int n;
        write_mode(2'b00);
        filt_over = 1'b1;
        wait_load(5000, n);
        check("R10 over data", int'(dreg_data), 32'hFFFFFF);
        check("R10 over err", int'(err_flag), 1);
        filt_over = 1'b0;
        filt_under = 1'b1;
        wait_load(5000, n);
        check("R10 under data", int'(dreg_data), 0);
        check("R10 under err", int'(err_flag), 1);
        filt_over = 1'b1;
        wait_load(5000, n);
        check("R10 both data", int'(dreg_data), 32'hFFFFFF);
        filt_over = 1'b0;
        filt_under = 1'b0;
        filt_data = 24'h00F00D;
        wait_load(5000, n);
        check("R10 clean data", int'(dreg_data), 32'h00F00D);
        check("R10 clean err", int'(err_flag), 0);
    endtask

    task automatic t_powerdown_err();
        int n;
        int c;
        write_mode(2'b00);
        filt_over = 1'b1;
        wait_load(5000, n);
        filt_over = 1'b0;
        check("R10 err set", int'(err_flag), 1);
        write_mode(2'b11);
        check("R11 err kept", int'(err_flag), 1);
        check("R7 pwr_down", int'(pwr_down), 1);
        check("R7 ready off", int'(rdy_n), 1);
        count_loads(3 * per(0, 0), c);
        check("R7 no loads", c, 0);
        write_mode(2'b01);
        check("R7 reserved off", int'(pwr_down), 1);
        count_loads(3 * per(0, 0), c);
        check("R7 reserved no loads", c, 0);
        write_mode(2'b00);
        check("R11 err cleared", int'(err_flag), 0);
        check("R11 pwr_down left", int'(pwr_down), 0);
    endtask

    task automatic t_single();
        int n;
        int c;
        write_mode(2'b10);
        check("R6 awake", int'(pwr_down), 0);
        wait_load(5000, n);
        check("R6 single timing", n, WAKE + 2 * per(0, 0));
        check("R6 ready low", int'(rdy_n), 0);
        check("R6 back to off", int'(pwr_down), 1);
        count_loads(3 * per(0, 0), c);
        check("R6 no more loads", c, 0);
        check("R6 ready held", int'(rdy_n), 0);
        read_done = 1'b1;
        @(negedge clk);
        read_done = 1'b0;
        check("R8 single read", int'(rdy_n), 1);
    endtask

    task automatic t_chan();
        int n;
        write_mode(2'b00);
        wait_load(5000, n);
        step(30);
        cfg_chan = 2'b01;
        @(negedge clk);
        check("R4 ready dropped", int'(rdy_n), 1);
        wait_load(5000, n);
        check("R4 channel settle", n, 2 * per(0, 0));
    endtask

    initial begin
        t_reset();
        t_rates();
        t_cdiv();
        t_blank_overwrite();
        t_read();
        t_clamp();
        t_powerdown_err();
        t_single();
        t_chan();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (LIMIT) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", LIMIT, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule